// File: doc/BRIEF.md
# Clock Source Selector with Failover

This block chooses which of three oscillators drives the system clock: the internal oscillator, the external oscillator, or the PLL output. Software requests a source through a write strobe. The switch happens only once the requested source reports ready, and a request that is not yet ready stays pending until it is. The block also holds the PLL setup: whether its reference is the internal or the external oscillator, whether the external reference is first divided by two, and the multiplication factor. For example, a factor of 9 on an undivided 8 MHz reference gives 72 MHz.

A failure monitor runs in the internal oscillator domain. It samples the external oscillator as a toggling level and counts internal cycles between its edges. If that count reaches a programmable limit while the monitor is enabled and the external oscillator claims to be ready, the block declares a failure. The system clock is then forced back to the internal oscillator, and a sticky interrupt flag is raised. While the flag is set, the block refuses any request for the external oscillator or the PLL. Clearing the flag releases the override.

The synthesis of the PLL and the glitch-free analog switching are not part of this block. It produces the mux select `clk_sel` and a status copy `cur_src` that follows the select one cycle later.

Top module: `clksel_top`

## Requirements
- R1: Source codes are 0 for internal, 1 for external and 2 for PLL. A write of code 3 is ignored, so `clk_sel` keeps its value.
- R2: After reset, `clk_sel` and `cur_src` are 0 (internal) and `fail_irq` is 0. The PLL setup outputs are: reference internal (`pll_ref_cfg`=0), no predivide (`pll_div2_cfg`=0) and multiplier equal to parameter MUL_RST (default 2).
- R3: A request written with `sel_wr` is applied to `clk_sel` at the sampling clock edge if the requested source's ready input is 1. Otherwise it is held pending and applied at the first edge where that ready input is 1. A newer write replaces a pending request.
- R4: `cur_src` equals the value `clk_sel` had one clock earlier.
- R5: The monitor is armed only while `mon_en`=1, `ext_rdy`=1 and `mon_limit` is nonzero. When armed, it declares a failure after `mon_limit` consecutive internal cycles without an edge on the two-flop-synchronized `ext_osc`. An oscillator that toggles faster than that never causes a failure.
- R6: On a failure, `fail_irq` becomes 1 and `clk_sel` is forced to 0 at the same edge, and any pending request is dropped. This holds whether the external oscillator was driving the clock directly or was the PLL reference.
- R7: While `fail_irq`=1, writes requesting code 1 or 2 are ignored. A write requesting code 0 is accepted.
- R8: A one-cycle `fail_clr` pulse clears `fail_irq` at the next edge, after which requests for codes 1 and 2 are accepted again. If a new failure is detected in the same cycle, the failure wins.
- R9: A `pll_wr` pulse loads `pll_ref_ext` (1 selects external), `pll_pre_div2` and `pll_mul`. The new values appear on `pll_ref_cfg`, `pll_div2_cfg` and `pll_mul_cfg` at the next edge.
- R10: While `clk_sel` is 2 (PLL), `pll_wr` is ignored and the PLL setup outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Source request strobe |
| sel_req | input | 2 | Requested source code |
| pll_wr | input | 1 | PLL setup write strobe |
| pll_ref_ext | input | 1 | PLL reference: 1 external, 0 internal |
| pll_pre_div2 | input | 1 | Divide external reference by two |
| pll_mul | input | MW | PLL multiplication factor |
| mon_en | input | 1 | Failure monitor enable |
| mon_limit | input | TW | Edge-free cycles before failure |
| fail_clr | input | 1 | Clears the failure flag |
| int_rdy | input | 1 | Internal oscillator ready |
| ext_rdy | input | 1 | External oscillator ready |
| pll_rdy | input | 1 | PLL locked and ready |
| ext_osc | input | 1 | External oscillator level, sampled |
| clk_sel | output | 2 | Active source select for the clock mux |
| cur_src | output | 2 | Current source status |
| fail_irq | output | 1 | Sticky failure interrupt flag |
| pll_ref_cfg | output | 1 | Stored PLL reference select |
| pll_div2_cfg | output | 1 | Stored predivide bit |
| pll_mul_cfg | output | MW | Stored multiplication factor |

## Verification
Consider a pending request that is lost or that sticks: it shows as `clk_sel` not moving when the ready input rises, or moving with no request, within a single cycle. An edge counter that is off shows as `fail_irq` rising too early while the oscillator still toggles, or never rising within about `mon_limit` plus three cycles after it stops. A status register that is off shows as `cur_src` disagreeing with the previous cycle's `clk_sel`. A leaky override shows as `clk_sel` leaving 0 after a request made while `fail_irq` is set.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_PLL = 2'd2,
        SRC_RSV = 2'd3
    } src_e;

    typedef struct packed {
        src_e act;
        src_e pend;
        src_e stat;
        logic fail;
    } sw_state_t;

endpackage

// File: rtl/clksel_osc_mon.sv
module clksel_osc_mon #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_osc,
    input  logic          mon_en,
    input  logic          ext_rdy,
    input  logic          blocked,
    input  logic [TW-1:0] limit,
    output logic          fail_det
);

    localparam logic [TW-1:0] ONE = TW'(1);
    localparam logic [TW-1:0] SAT = {TW{1'b1}};

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          last;
        logic [TW-1:0] cnt;
    } mon_t;

    mon_t state_d, state_q;
    logic edge_seen;
    logic armed;

    always_comb begin
        state_d      = state_q;
        state_d.s1   = ext_osc;
        state_d.s2   = state_q.s1;
        state_d.last = state_q.s2;
        edge_seen    = state_q.s2 ^ state_q.last;
        armed        = mon_en & ext_rdy & ~blocked & (limit != '0);
        if (!armed || edge_seen) begin
            state_d.cnt = '0;
        end else if (state_q.cnt != SAT) begin
            state_d.cnt = state_q.cnt + ONE;
        end
        fail_det = armed & ~edge_seen & (state_q.cnt >= (limit - ONE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R5: a failure is only declared with the monitor armed
    a_r5_fail_armed: assert property (@(posedge clk) disable iff (!rst_n)
        fail_det |-> (mon_en && ext_rdy && !blocked));

    // R5: a detected edge always restarts the edge-free count
    a_r5_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s2 != state_q.last) |=> (state_q.cnt == '0));

endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_req,
    input  logic       int_rdy,
    input  logic       ext_rdy,
    input  logic       pll_rdy,
    input  logic       fail_det,
    input  logic       fail_clr,
    output src_e       act_src,
    output src_e       stat_src,
    output logic       fail_flag
);

    sw_state_t state_d, state_q;
    src_e      want;
    logic      want_rdy;
    logic      wr_ok;

    always_comb begin
        state_d = state_q;
        want    = state_q.pend;
        wr_ok   = sel_wr && (sel_req != SRC_RSV) &&
                  (!state_q.fail || (sel_req == SRC_INT));
        if (wr_ok) begin
            want = src_e'(sel_req);
        end
        case (want)
            SRC_INT: want_rdy = int_rdy;
            SRC_EXT: want_rdy = ext_rdy;
            SRC_PLL: want_rdy = pll_rdy;
            default: want_rdy = 1'b0;
        endcase
        state_d.pend = want;
        if ((want != state_q.act) && want_rdy) begin
            state_d.act = want;
        end
        state_d.stat = state_q.act;
        if (fail_clr) begin
            state_d.fail = 1'b0;
        end
        if (fail_det) begin
            state_d.fail = 1'b1;
            state_d.act  = SRC_INT;
            state_d.pend = SRC_INT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{act: SRC_INT, pend: SRC_INT, stat: SRC_INT, fail: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign act_src   = state_q.act;
    assign stat_src  = state_q.stat;
    assign fail_flag = state_q.fail;

    // R1: the reserved code never becomes the active source
    a_r1_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.act != SRC_RSV);

    // R3: a move onto the external oscillator needs it ready
    a_r3_ext_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(state_q.act) && state_q.act == SRC_EXT) |-> $past(ext_rdy));

    // R3: a move onto the PLL needs it ready
    a_r3_pll_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(state_q.act) && state_q.act == SRC_PLL) |-> $past(pll_rdy));

    // R6 / R7: with the flag up, only the internal oscillator is active
    a_r6_fail_internal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.fail |-> (state_q.act == SRC_INT));

    // R8: the flag stays up until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.fail && !fail_clr) |=> state_q.fail);

endmodule

// File: rtl/clksel_pll_cfg.sv
module clksel_pll_cfg #(
    parameter int MW      = 5,
    parameter int MUL_RST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          ref_ext,
    input  logic          pre_div2,
    input  logic [MW-1:0] mul,
    input  logic          pll_active,
    output logic          ref_cfg,
    output logic          div2_cfg,
    output logic [MW-1:0] mul_cfg
);

    typedef struct packed {
        logic          ref_ext;
        logic          div2;
        logic [MW-1:0] mul;
    } cfg_t;

    cfg_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_wr && !pll_active) begin
            state_d.ref_ext = ref_ext;
            state_d.div2    = pre_div2;
            state_d.mul     = mul;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{ref_ext: 1'b0, div2: 1'b0, mul: MW'(MUL_RST)};
        end else begin
            state_q <= state_d;
        end
    end

    assign ref_cfg  = state_q.ref_ext;
    assign div2_cfg = state_q.div2;
    assign mul_cfg  = state_q.mul;

    // R10: setup frozen while the PLL drives the clock
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pll_active |=> $stable(state_q));

    // R9: setup only moves after a write strobe
    a_r9_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(state_q));

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int TW      = 8,
    parameter int MW      = 5,
    parameter int MUL_RST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic [1:0]    sel_req,
    input  logic          pll_wr,
    input  logic          pll_ref_ext,
    input  logic          pll_pre_div2,
    input  logic [MW-1:0] pll_mul,
    input  logic          mon_en,
    input  logic [TW-1:0] mon_limit,
    input  logic          fail_clr,
    input  logic          int_rdy,
    input  logic          ext_rdy,
    input  logic          pll_rdy,
    input  logic          ext_osc,
    output logic [1:0]    clk_sel,
    output logic [1:0]    cur_src,
    output logic          fail_irq,
    output logic          pll_ref_cfg,
    output logic          pll_div2_cfg,
    output logic [MW-1:0] pll_mul_cfg
);

    src_e act_src;
    src_e stat_src;
    logic fail_det;
    logic fail_flag;

    clksel_osc_mon #(.TW(TW)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_osc  (ext_osc),
        .mon_en   (mon_en),
        .ext_rdy  (ext_rdy),
        .blocked  (fail_flag),
        .limit    (mon_limit),
        .fail_det (fail_det)
    );

    clksel_switch u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_req   (sel_req),
        .int_rdy   (int_rdy),
        .ext_rdy   (ext_rdy),
        .pll_rdy   (pll_rdy),
        .fail_det  (fail_det),
        .fail_clr  (fail_clr),
        .act_src   (act_src),
        .stat_src  (stat_src),
        .fail_flag (fail_flag)
    );

    clksel_pll_cfg #(.MW(MW), .MUL_RST(MUL_RST)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (pll_wr),
        .ref_ext    (pll_ref_ext),
        .pre_div2   (pll_pre_div2),
        .mul        (pll_mul),
        .pll_active (act_src == SRC_PLL),
        .ref_cfg    (pll_ref_cfg),
        .div2_cfg   (pll_div2_cfg),
        .mul_cfg    (pll_mul_cfg)
    );

    assign clk_sel  = act_src;
    assign cur_src  = stat_src;
    assign fail_irq = fail_flag;

    // R6: a detected failure lands on the internal source at the next edge
    a_r6_forced_int: assert property (@(posedge clk) disable iff (!rst_n)
        fail_det |=> (clk_sel == 2'd0 && fail_irq));

endmodule

// File: tb/test_clksel_top.sv
module test_clksel_top;

    localparam int TW = 8;
    localparam int MW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_wr;
    logic [1:0]    sel_req;
    logic          pll_wr;
    logic          pll_ref_ext;
    logic          pll_pre_div2;
    logic [MW-1:0] pll_mul;
    logic          mon_en;
    logic [TW-1:0] mon_limit;
    logic          fail_clr;
    logic          int_rdy;
    logic          ext_rdy;
    logic          pll_rdy;
    logic          ext_osc;
    logic [1:0]    clk_sel;
    logic [1:0]    cur_src;
    logic          fail_irq;
    logic          pll_ref_cfg;
    logic          pll_div2_cfg;
    logic [MW-1:0] pll_mul_cfg;

    int checks = 0;
    int errors = 0;
    logic ext_run = 1'b0;
    int tgl = 0;

    always #4 clk = ~clk;

    clksel_top #(.TW(TW), .MW(MW), .MUL_RST(2)) i_clksel_top (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_req(sel_req),
        .pll_wr(pll_wr), .pll_ref_ext(pll_ref_ext), .pll_pre_div2(pll_pre_div2),
        .pll_mul(pll_mul), .mon_en(mon_en), .mon_limit(mon_limit),
        .fail_clr(fail_clr), .int_rdy(int_rdy), .ext_rdy(ext_rdy),
        .pll_rdy(pll_rdy), .ext_osc(ext_osc), .clk_sel(clk_sel),
        .cur_src(cur_src), .fail_irq(fail_irq), .pll_ref_cfg(pll_ref_cfg),
        .pll_div2_cfg(pll_div2_cfg), .pll_mul_cfg(pll_mul_cfg)
    );

    // vector: {wr, sel[1:0], ext_rdy, pll_rdy, expected clk_sel[1:0]}
    localparam logic [6:0] VEC [9] = '{
        {1'b1, 2'd1, 1'b1, 1'b0, 2'd1},  // switch to external
        {1'b1, 2'd2, 1'b1, 1'b0, 2'd1},  // PLL not ready: pending
        {1'b0, 2'd0, 1'b1, 1'b1, 2'd2},  // PLL ready: pending completes
        {1'b1, 2'd3, 1'b1, 1'b1, 2'd2},  // reserved code ignored (R1)
        {1'b1, 2'd0, 1'b1, 1'b1, 2'd0},  // back to internal
        {1'b1, 2'd2, 1'b1, 1'b1, 2'd2},  // PLL at once
        {1'b1, 2'd1, 1'b0, 1'b1, 2'd2},  // external not ready
        {1'b1, 2'd0, 1'b0, 1'b1, 2'd0},  // internal replaces pending
        {1'b0, 2'd0, 1'b1, 1'b1, 2'd0}   // old pending gone
    };

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic req_src(input logic [1:0] s);
        sel_req = s;
        sel_wr  = 1'b1;
        @(negedge clk);
        sel_wr  = 1'b0;
    endtask

    // external oscillator model: toggles every two cycles while running
    initial begin
        forever begin
            @(negedge clk);
            if (ext_run) begin
                tgl++;
                if (tgl % 2 == 0) ext_osc = ~ext_osc;
            end
        end
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        rst_n = 1'b0; sel_wr = 1'b0; sel_req = 2'd0; pll_wr = 1'b0;
        pll_ref_ext = 1'b0; pll_pre_div2 = 1'b0; pll_mul = '0;
        mon_en = 1'b0; mon_limit = 8'd8; fail_clr = 1'b0;
        int_rdy = 1'b1; ext_rdy = 1'b0; pll_rdy = 1'b0; ext_osc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2 clk_sel", clk_sel, 0);
        chk("R2 cur_src", cur_src, 0);
        chk("R2 fail_irq", fail_irq, 0);
        chk("R2 pll_ref_cfg", pll_ref_cfg, 0);
        chk("R2 pll_div2_cfg", pll_div2_cfg, 0);
        chk("R2 pll_mul_cfg", pll_mul_cfg, 2);

        // R3 / R4 table
        prev = 2'd0;
        for (int i = 0; i < 9; i++) begin
            logic [6:0] v;
            v = VEC[i];
            sel_wr  = v[6];
            sel_req = v[5:4];
            ext_rdy = v[3];
            pll_rdy = v[2];
            @(negedge clk);
            sel_wr = 1'b0;
            chk("R3 clk_sel", clk_sel, v[1:0]);
            chk("R4 cur_src lag", cur_src, prev);
            @(negedge clk);
            chk("R4 cur_src", cur_src, v[1:0]);
            prev = v[1:0];
        end

        // R9 setup write while on internal
        pll_ref_ext = 1'b1; pll_pre_div2 = 1'b1; pll_mul = 5'd9; pll_wr = 1'b1;
        @(negedge clk);
        pll_wr = 1'b0;
        chk("R9 pll_ref_cfg", pll_ref_cfg, 1);
        chk("R9 pll_div2_cfg", pll_div2_cfg, 1);
        chk("R9 pll_mul_cfg", pll_mul_cfg, 9);

        // R10 setup frozen while PLL active
        req_src(2'd2);
        chk("R10 on PLL", clk_sel, 2);
        pll_ref_ext = 1'b0; pll_pre_div2 = 1'b0; pll_mul = 5'd4; pll_wr = 1'b1;
        @(negedge clk);
        pll_wr = 1'b0;
        @(negedge clk);
        chk("R10 pll_ref_cfg", pll_ref_cfg, 1);
        chk("R10 pll_div2_cfg", pll_div2_cfg, 1);
        chk("R10 pll_mul_cfg", pll_mul_cfg, 9);

        // R5 not armed: monitor off, oscillator stopped
        ext_rdy = 1'b1;
        repeat (30) @(negedge clk);
        chk("R5 disabled", fail_irq, 0);
        mon_en = 1'b1; ext_rdy = 1'b0;
        repeat (30) @(negedge clk);
        chk("R5 not ready", fail_irq, 0);
        ext_rdy = 1'b1; ext_run = 1'b1;
        repeat (40) @(negedge clk);
        chk("R5 toggling", fail_irq, 0);
        chk("R5 still PLL", clk_sel, 2);

        // R5 / R6 stop while external feeds the PLL
        ext_run = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 stopped", fail_irq, 1);
        chk("R6 clk_sel", clk_sel, 0);
        chk("R6 cur_src", cur_src, 0);

        // R7 override
        req_src(2'd1);
        @(negedge clk);
        chk("R7 ext blocked", clk_sel, 0);
        req_src(2'd2);
        @(negedge clk);
        chk("R7 pll blocked", clk_sel, 0);
        chk("R7 flag held", fail_irq, 1);

        // R8 clear releases
        mon_en = 1'b0; fail_clr = 1'b1;
        @(negedge clk);
        fail_clr = 1'b0;
        chk("R8 cleared", fail_irq, 0);
        req_src(2'd1);
        chk("R8 ext accepted", clk_sel, 1);

        // R1 reserved code has no effect
        req_src(2'd3);
        chk("R1 reserved", clk_sel, 1);
        @(negedge clk);
        chk("R1 reserved later", clk_sel, 1);

        // R6 stop while external drives the clock directly
        mon_en = 1'b1; ext_run = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6 running ext", fail_irq, 0);
        ext_run = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 direct flag", fail_irq, 1);
        chk("R6 direct clk_sel", clk_sel, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule